// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Instruction Decode

This block is the test access port of a device. It tracks the standard sixteen-state test controller on the test clock, using the mode-select input and a synchronous reset. It owns a 6-bit instruction register and, through an instruction decoder, steers every data-register scan to one of four targets:

- the 1-bit bypass stage;
- a 32-bit identification register;
- a 32-bit user code register, which shares the identification shift path;
- an external boundary-scan chain, which the block serves through strobes and a serial return input.

The serial output is registered on the falling edge of the test clock. It is enabled only while a shift state is active, and the enable is brought out so that a pad can tri-state the pin.

The decoded instruction also drives two mode outputs for the boundary cells. The first tells the cells to drive the device pins from their update latches, which is external-test drive. The second disables every output of the device. Both modes change only when a new instruction is committed or when the controller resets.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: With `trst` high at a rising edge of `tck`, the controller enters Test-Logic-Reset. One cycle later `tdo_oe` and `tdo` read 0, `bnd_drive` and `out_disable` read 0, and the boundary strobes read 0. Leaving reset, the active instruction is IDCODE.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. The following rising edge there restores the IDCODE instruction.
- R3: The state sequence follows the standard test controller graph. This includes the Pause/Exit2 paths, and a scan that pauses resumes shifting where it stopped.
- R4: In Capture-IR the instruction shift stage loads 000001, so bit 0 = 1 and bit 1 = 0. In Shift-IR it shifts toward bit 0 with `tdi` entering bit 5, and bit 0 appears on `tdo`. Update-IR commits the shift stage as the active instruction.
- R5: The opcode map, written bit 5 down to bit 0, is as follows:
  - 001001 selects identification.
  - 001000 selects user code.
  - 111111 selects bypass.
  - 001010 selects bypass with output disable.
  - 000001 (sample and preload share this code) selects the boundary chain.
  - 100110, 111100 and 111101 select the boundary chain with external-test drive.
  - Every other code acts as bypass with no mode.
- R6: With identification selected, Capture-DR loads `IDCODE` and Shift-DR sends it out LSB first, with `tdi` entering the MSB.
- R7: With user code selected, Capture-DR loads `USERCODE` into the same 32-bit path, and it is shifted the same way.
- R8: With bypass selected, Capture-DR loads 0. Each Shift-DR cycle then moves `tdi` through exactly one stage, so the output of shift n is the input of shift n-1.
- R9: `bnd_capture`, `bnd_shift` and `bnd_update` are high exactly while the controller is in Capture-DR, Shift-DR and Update-DR, and only when the boundary chain is selected. While it shifts, `tdo` carries `bnd_so`.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_oe` is 0.
- R11: `bnd_drive` is 1 for the three external-test codes and `out_disable` is 1 for the output-disable code. The two are never both 1, and they change only at the rising edge leaving Update-IR or Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_oe | output | 1 | Output enable for the tdo pad |
| bnd_capture | output | 1 | Boundary chain capture strobe |
| bnd_shift | output | 1 | Boundary chain shift strobe |
| bnd_update | output | 1 | Boundary chain update strobe |
| bnd_drive | output | 1 | External-test drive mode for the boundary cells |
| out_disable | output | 1 | Global output disable mode |

## Verification
Several properties are checked on every cycle:
- five high `tms` edges always land in Test-Logic-Reset;
- reset restores the IDCODE instruction;
- Capture-IR leaves the low bits at 01, and a captured bypass stage holds 0;
- the two modes are exclusive and hold still outside Update-IR and reset;
- the strobes are one-hot and only reach the boundary chain when it is selected;
- `tdo_oe` is seen only in shift states, with `tdo` quiet otherwise.

Only the bench scenarios can show the rest. That covers the full content and order of the identification and user words, the one-stage bypass delay, resuming a paused scan, the full opcode map including undefined codes, and a reset arriving in the middle of a scan.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  localparam int IR_W = 6;

  localparam logic [IR_W-1:0] OP_IDCODE    = 6'b001001;
  localparam logic [IR_W-1:0] OP_USERCODE  = 6'b001000;
  localparam logic [IR_W-1:0] OP_BYPASS    = 6'b111111;
  localparam logic [IR_W-1:0] OP_HIGHZ     = 6'b001010;
  localparam logic [IR_W-1:0] OP_SAMPLE    = 6'b000001;
  localparam logic [IR_W-1:0] OP_EXTEST    = 6'b100110;
  localparam logic [IR_W-1:0] OP_EXT_PULSE = 6'b111100;
  localparam logic [IR_W-1:0] OP_EXT_TRAIN = 6'b111101;

  // value loaded into the instruction shift stage in Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE   = 6'b000001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDENT, DR_USER, DR_BOUND
  } dr_sel_t;

  typedef struct packed {
    dr_sel_t sel;
    logic    drive;
    logic    hiz;
  } ir_decode_t;

  function automatic ir_decode_t decode_ir(input logic [IR_W-1:0] op);
    ir_decode_t d;
    d.sel   = DR_BYPASS;
    d.drive = 1'b0;
    d.hiz   = 1'b0;
    case (op)
      OP_IDCODE:   d.sel = DR_IDENT;
      OP_USERCODE: d.sel = DR_USER;
      OP_SAMPLE:   d.sel = DR_BOUND;
      OP_EXTEST, OP_EXT_PULSE, OP_EXT_TRAIN: begin
        d.sel   = DR_BOUND;
        d.drive = 1'b1;
      end
      OP_HIGHZ:    d.hiz = 1'b1;
      default:     d.sel = DR_BYPASS;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state,
  output tap_state_t state_nxt
);

  always_comb begin
    case (state)
      ST_RESET:  state_nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= state_nxt;
  end

  // checker: run length of consecutive high tms edges, saturating at five
  logic [2:0] ones_cnt;
  always_ff @(posedge tck) begin
    if (rst || !tms)          ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic            ir_so,
  output dr_sel_t         dr_sel,
  output logic            bnd_drive,
  output logic            out_disable
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_hold;
  ir_decode_t      dec_sr;
  ir_decode_t      dec_hold;

  assign dec_sr   = decode_ir(ir_sr);
  assign dec_hold = decode_ir(ir_hold);
  assign dr_sel   = dec_hold.sel;
  assign ir_so    = ir_sr[0];

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr       <= '0;
      ir_hold     <= OP_IDCODE;
      bnd_drive   <= 1'b0;
      out_disable <= 1'b0;
    end else begin
      case (state)
        ST_RESET: begin
          ir_hold     <= OP_IDCODE;
          bnd_drive   <= 1'b0;
          out_disable <= 1'b0;
        end
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: begin
          ir_hold     <= ir_sr;
          bnd_drive   <= dec_sr.drive;
          out_disable <= dec_sr.hiz;
        end
        default: ;
      endcase
    end
  end

  a_r1_reset_restores_idcode: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> (ir_hold == OP_IDCODE));

  a_r4_capture_low_bits: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  a_r11_modes_exclusive: assert property (@(posedge tck) disable iff (rst)
    !(bnd_drive && out_disable));

  a_r11_modes_hold: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_RESET) |=>
      ($stable(bnd_drive) && $stable(out_disable) && $stable(ir_hold)));

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int               ID_W     = 32,
  parameter logic [ID_W-1:0]  IDCODE   = 32'h2A7C_5093,
  parameter logic [ID_W-1:0]  USERCODE = 32'h5EED_C0DE
)(
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_t state,
  input  dr_sel_t    dr_sel,
  input  logic       bnd_so,
  output logic       dr_so
);

  logic            bypass_q;
  logic [ID_W-1:0] id_sr;
  logic            use_id_path;

  assign use_id_path = (dr_sel == DR_IDENT) || (dr_sel == DR_USER);

  always_ff @(posedge tck) begin
    if (rst) begin
      bypass_q <= 1'b0;
      id_sr    <= '0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          bypass_q <= 1'b0;
          if (dr_sel == DR_IDENT)     id_sr <= IDCODE;
          else if (dr_sel == DR_USER) id_sr <= USERCODE;
        end
        ST_SHF_DR: begin
          if (dr_sel == DR_BYPASS) bypass_q <= tdi;
          if (use_id_path)         id_sr    <= {tdi, id_sr[ID_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dr_sel)
      DR_IDENT, DR_USER: dr_so = id_sr[0];
      DR_BOUND:          dr_so = bnd_so;
      default:           dr_so = bypass_q;
    endcase
  end

  a_r8_bypass_captures_zero: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR) |=> !bypass_q);

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int               ID_W     = 32,
  parameter logic [ID_W-1:0]  IDCODE   = 32'h2A7C_5093,
  parameter logic [ID_W-1:0]  USERCODE = 32'h5EED_C0DE
)(
  input  logic tck,
  input  logic trst,
  input  logic tms,
  input  logic tdi,
  input  logic bnd_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update,
  output logic bnd_drive,
  output logic out_disable
);

  tap_state_t state;
  tap_state_t state_nxt;
  dr_sel_t    dr_sel;
  logic       ir_so;
  logic       dr_so;
  logic       bnd_sel;

  jtag_tap_fsm u_fsm (
    .tck       (tck),
    .rst       (trst),
    .tms       (tms),
    .state     (state),
    .state_nxt (state_nxt)
  );

  jtag_tap_ir u_ir (
    .tck         (tck),
    .rst         (trst),
    .tdi         (tdi),
    .state       (state),
    .ir_so       (ir_so),
    .dr_sel      (dr_sel),
    .bnd_drive   (bnd_drive),
    .out_disable (out_disable)
  );

  jtag_tap_dr #(
    .ID_W     (ID_W),
    .IDCODE   (IDCODE),
    .USERCODE (USERCODE)
  ) u_dr (
    .tck    (tck),
    .rst    (trst),
    .tdi    (tdi),
    .state  (state),
    .dr_sel (dr_sel),
    .bnd_so (bnd_so),
    .dr_so  (dr_so)
  );

  assign bnd_sel = (dr_sel == DR_BOUND);

  // strobes registered from the next state so they are flop outputs
  always_ff @(posedge tck) begin
    if (trst) begin
      bnd_capture <= 1'b0;
      bnd_shift   <= 1'b0;
      bnd_update  <= 1'b0;
    end else begin
      bnd_capture <= bnd_sel && (state_nxt == ST_CAP_DR);
      bnd_shift   <= bnd_sel && (state_nxt == ST_SHF_DR);
      bnd_update  <= bnd_sel && (state_nxt == ST_UPD_DR);
    end
  end

  // serial output launched on the falling edge
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (state)
        ST_SHF_IR: begin tdo <= ir_so; tdo_oe <= 1'b1; end
        ST_SHF_DR: begin tdo <= dr_so; tdo_oe <= 1'b1; end
        default:   begin tdo <= 1'b0;  tdo_oe <= 1'b0; end
      endcase
    end
  end

  a_r10_oe_only_in_shift: assert property (@(posedge tck) disable iff (trst)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  a_r10_quiet_when_disabled: assert property (@(posedge tck) disable iff (trst)
    !tdo_oe |-> !tdo);

  a_r9_strobes_onehot0: assert property (@(posedge tck) disable iff (trst)
    $onehot0({bnd_capture, bnd_shift, bnd_update}));

  a_r9_strobes_need_bound: assert property (@(posedge tck) disable iff (trst)
    (bnd_capture || bnd_shift || bnd_update) |-> bnd_sel);

endmodule

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;

  localparam logic [31:0] IDV = 32'h2A7C_5093;
  localparam logic [31:0] USV = 32'h5EED_C0DE;

  localparam int S_RESET = 0,  S_IDLE = 1,
                 S_SEL_DR = 2, S_CAP_DR = 3, S_SHF_DR = 4, S_EX1_DR = 5,
                 S_PAU_DR = 6, S_EX2_DR = 7, S_UPD_DR = 8,
                 S_SEL_IR = 9, S_CAP_IR = 10, S_SHF_IR = 11, S_EX1_IR = 12,
                 S_PAU_IR = 13, S_EX2_IR = 14, S_UPD_IR = 15;

  logic tck = 1'b0;
  logic trst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bnd_so = 1'b0;
  logic tdo, tdo_oe, bnd_capture, bnd_shift, bnd_update, bnd_drive, out_disable;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 tck = ~tck;

  jtag_tap_ctrl #(.IDCODE(IDV), .USERCODE(USV)) u_dut (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .bnd_so(bnd_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bnd_capture(bnd_capture),
    .bnd_shift(bnd_shift), .bnd_update(bnd_update),
    .bnd_drive(bnd_drive), .out_disable(out_disable)
  );

  // ---------------- behavioural reference model ----------------
  int       m_st = S_RESET;
  bit [5:0] m_irsr = 6'b0;
  bit [5:0] m_ir = 6'b001001;
  bit       m_drive = 0;
  bit       m_hiz = 0;
  bit       m_q[$];

  function automatic int next_of(int s, bit t);
    case (s)
      S_RESET:  return t ? S_RESET  : S_IDLE;
      S_IDLE:   return t ? S_SEL_DR : S_IDLE;
      S_SEL_DR: return t ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: return t ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: return t ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: return t ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: return t ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: return t ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: return t ? S_SEL_DR : S_IDLE;
      S_SEL_IR: return t ? S_RESET  : S_CAP_IR;
      S_CAP_IR: return t ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: return t ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: return t ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: return t ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: return t ? S_UPD_IR : S_SHF_IR;
      default:  return t ? S_SEL_DR : S_IDLE;
    endcase
  endfunction

  // 0 bypass, 1 identification, 2 user code, 3 boundary
  function automatic int sel_of(bit [5:0] op);
    if (op == 6'b001001) return 1;
    if (op == 6'b001000) return 2;
    if (op == 6'b000001 || op == 6'b100110 || op == 6'b111100 || op == 6'b111101) return 3;
    return 0;
  endfunction

  always @(posedge tck) begin
    if (trst) begin
      m_st = S_RESET; m_ir = 6'b001001; m_irsr = 6'b0; m_drive = 0; m_hiz = 0;
    end else begin
      case (m_st)
        S_RESET:  begin m_ir = 6'b001001; m_drive = 0; m_hiz = 0; end
        S_CAP_IR: m_irsr = 6'b000001;
        S_SHF_IR: m_irsr = {tdi, m_irsr[5:1]};
        S_UPD_IR: begin
          m_ir = m_irsr;
          m_drive = (m_ir == 6'b100110 || m_ir == 6'b111100 || m_ir == 6'b111101);
          m_hiz = (m_ir == 6'b001010);
        end
        S_CAP_DR: begin
          m_q.delete();
          if (sel_of(m_ir) == 0) m_q.push_back(1'b0);
          else if (sel_of(m_ir) == 1) for (int i = 0; i < 32; i++) m_q.push_back(IDV[i]);
          else if (sel_of(m_ir) == 2) for (int i = 0; i < 32; i++) m_q.push_back(USV[i]);
        end
        S_SHF_DR: if (sel_of(m_ir) != 3 && m_q.size() > 0) begin
          void'(m_q.pop_front());
          m_q.push_back(tdi);
        end
        default: ;
      endcase
      m_st = next_of(m_st, tms);
    end
  end

  always @(negedge tck) begin
    bit e_oe, e_tdo, e_cap, e_shf, e_upd;
    int s;
    string tg;
    s = sel_of(m_ir);
    e_oe = (m_st == S_SHF_IR || m_st == S_SHF_DR);
    e_tdo = 1'b0;
    tg = "R10";
    if (m_st == S_SHF_IR) begin e_tdo = m_irsr[0]; tg = "R4 R10"; end
    else if (m_st == S_SHF_DR) begin
      if (s == 3) begin e_tdo = bnd_so; tg = "R5 R9"; end
      else begin
        e_tdo = (m_q.size() > 0) ? m_q[0] : 1'b0;
        tg = (s == 0) ? "R5 R8" : (s == 1) ? "R5 R6" : "R5 R7";
      end
    end
    e_cap = (m_st == S_CAP_DR) && s == 3;
    e_shf = (m_st == S_SHF_DR) && s == 3;
    e_upd = (m_st == S_UPD_DR) && s == 3;
    #1;
    vectors++;
    if (tdo_oe !== e_oe) begin fails++; $display("FAIL R3 R10 tdo_oe actual %b expected %b at %0t", tdo_oe, e_oe, $time); end
    if (tdo !== e_tdo) begin fails++; $display("FAIL %s tdo actual %b expected %b at %0t", tg, tdo, e_tdo, $time); end
    if ({bnd_capture, bnd_shift, bnd_update} !== {e_cap, e_shf, e_upd}) begin
      fails++; $display("FAIL R9 strobes actual %b expected %b at %0t",
        {bnd_capture, bnd_shift, bnd_update}, {e_cap, e_shf, e_upd}, $time);
    end
    if ({bnd_drive, out_disable} !== {m_drive, m_hiz}) begin
      fails++; $display("FAIL R11 modes actual %b expected %b at %0t",
        {bnd_drive, out_disable}, {m_drive, m_hiz}, $time);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic t, input logic d);
    tms = t; tdi = d; bnd_so = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    @(posedge tck); @(negedge tck); #3;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin dout[i] = tdo; step(i == n - 1, din[i]); end
    step(1, 0); step(0, 0);
  endtask

  task automatic ir_scan(input logic [5:0] op, output logic [5:0] cap);
    cap = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 6; i++) begin cap[i] = tdo; step(i == 5, op[i]); end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    logic [5:0]  c;
    step(1, 0); step(1, 0); step(1, 0);
    check("R1 reset outputs", {59'd0, tdo_oe, tdo, bnd_drive, out_disable, bnd_shift}, 64'd0);
    trst = 1'b0;
    step(0, 0);
    check("R10 idle oe", {63'd0, tdo_oe}, 64'd0);

    dr_scan(32, 64'hFFFF_0000, w);
    check("R1 R6 idcode after reset", w[31:0], IDV);

    ir_scan(6'b111111, c);
    check("R4 capture pattern", c, 6'b000001);
    dr_scan(8, 64'hA5, w);
    check("R5 R8 bypass delay", w[7:0], {8'hA5 << 1});

    // five high tms edges from inside Shift-DR
    step(1, 0); step(0, 0); step(0, 1);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    dr_scan(32, 64'h0, w);
    check("R2 five ones restores idcode", w[31:0], IDV);

    ir_scan(6'b001000, c);
    dr_scan(40, 64'h12_3456_789A, w);
    check("R5 R7 usercode", w[31:0], USV);
    check("R7 shared path delay", w[39:32], 8'h9A);

    ir_scan(6'b100110, c);
    check("R5 R11 extest drive", {bnd_drive, out_disable}, 2'b10);
    dr_scan(16, 64'h5A5A, w);
    ir_scan(6'b111100, c);
    check("R5 R11 pulse drive", {bnd_drive, out_disable}, 2'b10);
    dr_scan(5, 64'h3, w);
    ir_scan(6'b111101, c);
    check("R5 R11 train drive", {bnd_drive, out_disable}, 2'b10);
    ir_scan(6'b000001, c);
    check("R5 R11 sample no mode", {bnd_drive, out_disable}, 2'b00);
    dr_scan(12, 64'hC3C, w);

    ir_scan(6'b001010, c);
    check("R5 R11 highz disable", {bnd_drive, out_disable}, 2'b01);
    dr_scan(8, 64'h3C, w);
    check("R5 R8 highz bypass", w[7:0], {8'h3C << 1});

    ir_scan(6'b010000, c);
    check("R5 R11 undefined no mode", {bnd_drive, out_disable}, 2'b00);
    dr_scan(8, 64'hE1, w);
    check("R5 R8 undefined bypass", w[7:0], {8'hE1 << 1});

    // paused identification scan
    ir_scan(6'b001001, c);
    w = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) begin w[i] = tdo; step(i == 9, 0); end
    step(0, 0); step(0, 0);
    check("R10 paused oe", {63'd0, tdo_oe}, 64'd0);
    step(1, 0); step(0, 0);
    for (int i = 10; i < 32; i++) begin w[i] = tdo; step(i == 31, 0); end
    step(1, 0); step(0, 0);
    check("R3 paused scan resumes", w[31:0], IDV);

    // reset in the middle of a boundary scan
    ir_scan(6'b100110, c);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 0);
    trst = 1'b1;
    step(0, 0);
    check("R1 reset mid scan", {61'd0, tdo_oe, bnd_drive, bnd_shift}, 64'd0);
    trst = 1'b0;
    step(0, 0);
    dr_scan(32, 64'h0, w);
    check("R1 idcode after mid scan reset", w[31:0], IDV);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule